// File: doc/BRIEF.md
# Multi-Channel Byte DMA Sequencer

This block moves single bytes between a wide memory address space (the A side) and a 256-entry peripheral register window (the B side). The window is mapped at a fixed base in the A-side address space. Up to eight channels are armed at once. One start pulse latches every channel's settings, and the block then serves the armed channels one after another, lowest index first. For each byte it issues a read strobe and then a write strobe on one shared address/data port, with a fixed number of clock cycles before each strobe.

Each channel holds four settings:
- a direction bit;
- a memory address, which steps up by one after every byte;
- a register offset, which follows one of four short repeating offset patterns;
- a byte count.

One address combination makes the memory-data register both the source and the destination. When the block sees it, it does not perform a normal move. Instead it follows a direction-dependent conflict rule, and the byte still takes the same number of cycles.

When every armed channel has finished, busy drops and an interrupt-lock output stays high for a short fixed window. The block is used as the burst-copy engine next to a processor. The processor arms channels and pulses start, and the lock window then holds off interrupt entry briefly after the burst.

Top module: `dma_seq`

## Requirements
- R1: Armed channels are served strictly in ascending index order; a channel whose enable bit is clear at start produces no strobes and no setup time.
- R2: busy_o rises in the cycle after the start pulse is sampled. A run spends 8 overhead cycles before the first channel, and each served channel spends 8 setup cycles before its first byte.
- R3: A normal byte takes 8 cycles. rd_o is high alone in its 4th cycle and wr_o is high alone in its 8th cycle, and wdata_o equals the byte returned on rdata_i during the read strobe.
- R4: Direction 0 reads the memory address and writes address 0x002100 OR offset. Direction 1 reads 0x002100 OR offset and writes the memory address.
- R5: A byte is a conflict byte when its current offset is 0x80 and its memory address either has bits 23..17 equal to 0x3F (bank 0x7E or 0x7F) or has bits 22, 15, 14 and 13 all zero.
- R6: A conflict byte in direction 0 lasts 8 cycles and raises neither strobe.
- R7: A conflict byte in direction 1 lasts 8 cycles, raises no read, and writes 0x00 to the memory address in its 8th cycle.
- R8: A channel moves exactly its byte count of bytes; a count of 0 means 2^CNT_W bytes.
- R9: The memory address steps up by one after every byte, wrapping modulo 2^24, starting from the channel's programmed address.
- R10: The offset added to a channel's base offset for its k-th byte (k counted from 0 per channel, modulo 8 bits) is, by pattern code: 0 → always 0; 1 → 0,1,0,1…; 2 → 0,0,1,1,…; 3 → 0,1,2,3,….
- R11: en_o shows the latched enable bits. A channel's bit clears at the end of its last byte, the other bits are unchanged, and no bit is set except by start.
- R12: When the last channel finishes (or right after the run overhead if none is armed), busy_o falls and lock_o is high for exactly 2 cycles.
- R13: A start pulse while busy_o or lock_o is high is ignored and does not change the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; latches all channel settings when idle |
| cfg_en_i | input | NCH | Per-channel enable |
| cfg_dir_i | input | NCH | Per-channel direction (0: memory to register) |
| cfg_addr_i | input | NCH*AW | Per-channel memory start address |
| cfg_off_i | input | NCH*8 | Per-channel base register offset |
| cfg_pat_i | input | NCH*2 | Per-channel offset pattern code |
| cfg_cnt_i | input | NCH*CNT_W | Per-channel byte count (0 = 2^CNT_W) |
| rdata_i | input | 8 | Read data, valid while rd_o is high |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| addr_o | output | AW | Address for the active strobe |
| wdata_o | output | 8 | Write data, valid while wr_o is high |
| busy_o | output | 1 | Run in progress |
| lock_o | output | 1 | Interrupt-lock window |
| en_o | output | NCH | Remaining enable bits |

## Verification
A wrong sub-cycle counter shifts every later strobe of the run, so the cycle stamp of the first affected strobe differs from the model within one byte time, and the lock rise moves too. A wrong offset-pattern index, address step or conflict decision shows as a wrong address or data on the very next strobe, or as a strobe that is missing or extra. A wrong remaining count or channel pick changes the total number of strobes and the lock cycle by whole 8-cycle bytes, and the en_o probe mid-run shows an enable bit that clears early, late or in the wrong order.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RUNOH,
      ST_SETUP,
      ST_XFER,
      ST_LOCK
   } seq_state_e;

   // Offset step for pattern code pat at byte index idx
   function automatic logic [7:0] pat_delta(input logic [1:0] pat, input logic [1:0] idx);
      logic [7:0] d;
      case (pat)
         2'd0:    d = 8'd0;
         2'd1:    d = {7'd0, idx[0]};
         2'd2:    d = {7'd0, idx[1]};
         default: d = {6'd0, idx};
      endcase
      return d;
   endfunction

endpackage

// File: rtl/dma_seq_pick.sv
module dma_seq_pick #(
   parameter int NCH   = 8,
   localparam int IDX_W = $clog2(NCH)
) (
   input  logic [NCH-1:0]   req_i,
   output logic             valid_o,
   output logic [IDX_W-1:0] idx_o
);

   always_comb begin
      idx_o   = '0;
      valid_o = |req_i;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (req_i[i]) idx_o = IDX_W'(i);
      end
   end

endmodule

// File: rtl/dma_seq_chan_bank.sv
module dma_seq_chan_bank #(
   parameter int NCH   = 8,
   parameter int AW    = 24,
   parameter int CNT_W = 16,
   localparam int IDX_W = $clog2(NCH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_i,
   input  logic [NCH-1:0]     cfg_en_i,
   input  logic [NCH-1:0]     cfg_dir_i,
   input  logic [NCH*AW-1:0]  cfg_addr_i,
   input  logic [NCH*8-1:0]   cfg_off_i,
   input  logic [NCH*2-1:0]   cfg_pat_i,
   input  logic [NCH*CNT_W-1:0] cfg_cnt_i,
   input  logic               clr_i,
   input  logic [IDX_W-1:0]   sel_i,
   output logic [NCH-1:0]     en_o,
   output logic               sel_dir_o,
   output logic [AW-1:0]      sel_addr_o,
   output logic [7:0]         sel_off_o,
   output logic [1:0]         sel_pat_o,
   output logic [CNT_W-1:0]   sel_cnt_o
);

   logic [NCH-1:0]   en_q;
   logic [NCH-1:0]   dir_q;
   logic [AW-1:0]    addr_q [NCH];
   logic [7:0]       off_q  [NCH];
   logic [1:0]       pat_q  [NCH];
   logic [CNT_W-1:0] cnt_q  [NCH];

   for (genvar g = 0; g < NCH; g++) begin : g_chan
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_q[g]   <= 1'b0;
            dir_q[g]  <= 1'b0;
            addr_q[g] <= '0;
            off_q[g]  <= '0;
            pat_q[g]  <= '0;
            cnt_q[g]  <= '0;
         end else if (load_i) begin
            en_q[g]   <= cfg_en_i[g];
            dir_q[g]  <= cfg_dir_i[g];
            addr_q[g] <= cfg_addr_i[g*AW +: AW];
            off_q[g]  <= cfg_off_i[g*8 +: 8];
            pat_q[g]  <= cfg_pat_i[g*2 +: 2];
            cnt_q[g]  <= cfg_cnt_i[g*CNT_W +: CNT_W];
         end else if (clr_i && (sel_i == IDX_W'(g))) begin
            en_q[g]   <= 1'b0;
         end
      end
   end

   assign en_o       = en_q;
   assign sel_dir_o  = dir_q[sel_i];
   assign sel_addr_o = addr_q[sel_i];
   assign sel_off_o  = off_q[sel_i];
   assign sel_pat_o  = pat_q[sel_i];
   assign sel_cnt_o  = cnt_q[sel_i];

   AST_EN_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> ((en_q & ~$past(en_q)) == '0)); // R11

   AST_CLR_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !load_i) |=> ($countones($past(en_q) ^ en_q) <= 1)); // R11

endmodule

// File: rtl/dma_seq_engine.sv
module dma_seq_engine
   import dma_seq_pkg::*;
#(
   parameter int          NCH      = 8,
   parameter int          AW       = 24,
   parameter int          CNT_W    = 16,
   parameter int          RUN_OH   = 8,
   parameter int          SETUP_OH = 8,
   parameter int          HALF     = 4,
   parameter int          LOCK_LEN = 2,
   parameter logic [AW-1:0] B_BASE  = 24'h002100,
   parameter logic [AW-1:0] C_MASK0 = 24'hFE0000,
   parameter logic [AW-1:0] C_VAL0  = 24'h7E0000,
   parameter logic [AW-1:0] C_MASK1 = 24'h40E000,
   parameter logic [7:0]    C_PORT  = 8'h80,
   localparam int IDX_W = $clog2(NCH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [NCH-1:0]   en_i,
   input  logic             sel_dir_i,
   input  logic [AW-1:0]    sel_addr_i,
   input  logic [7:0]       sel_off_i,
   input  logic [1:0]       sel_pat_i,
   input  logic [CNT_W-1:0] sel_cnt_i,
   input  logic [7:0]       rdata_i,
   output logic             load_o,
   output logic             clr_o,
   output logic [IDX_W-1:0] sel_o,
   output logic             rd_o,
   output logic             wr_o,
   output logic [AW-1:0]    addr_o,
   output logic [7:0]       wdata_o,
   output logic             busy_o,
   output logic             lock_o
);

   localparam int BYTE_LEN = 2 * HALF;
   localparam int MAX_A    = (RUN_OH > SETUP_OH) ? RUN_OH : SETUP_OH;
   localparam int MAX_B    = (BYTE_LEN > LOCK_LEN) ? BYTE_LEN : LOCK_LEN;
   localparam int MAX_U    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int UW       = $clog2(MAX_U + 1);
   localparam int RW       = CNT_W + 1;

   localparam logic [UW-1:0] U_RUN_END  = UW'(RUN_OH - 1);
   localparam logic [UW-1:0] U_SET_END  = UW'(SETUP_OH - 1);
   localparam logic [UW-1:0] U_RD       = UW'(HALF - 1);
   localparam logic [UW-1:0] U_BYTE_END = UW'(BYTE_LEN - 1);
   localparam logic [UW-1:0] U_LOCK_END = UW'(LOCK_LEN - 1);
   localparam logic [RW-1:0] REM_ONE    = RW'(1);
   localparam logic [RW-1:0] REM_FULL   = {1'b1, {CNT_W{1'b0}}};

   seq_state_e       state_q;
   logic [UW-1:0]    unit_q;
   logic [IDX_W-1:0] ch_q;
   logic             dir_q;
   logic [AW-1:0]    addr_q;
   logic [7:0]       off_base_q;
   logic [1:0]       pat_q;
   logic [1:0]       pidx_q;
   logic [RW-1:0]    rem_q;
   logic [7:0]       dbuf_q;

   logic             in_x, rd_ph, wr_ph, byte_end, last_byte, conflict;
   logic [7:0]       cur_off;
   logic [AW-1:0]    b_addr;
   logic [NCH-1:0]   pick_req, self_mask;
   logic             nxt_valid;
   logic [IDX_W-1:0] nxt_idx;

   // Channel pick: remaining enables minus the channel now running
   always_comb begin
      self_mask = '0;
      if (in_x) self_mask[ch_q] = 1'b1;
   end
   assign pick_req = en_i & ~self_mask;

   dma_seq_pick #(.NCH(NCH)) u_pick (
      .req_i   (pick_req),
      .valid_o (nxt_valid),
      .idx_o   (nxt_idx)
   );

   // Per-byte address and conflict decode
   assign cur_off  = off_base_q + pat_delta(pat_q, pidx_q);
   assign b_addr   = B_BASE | {{(AW-8){1'b0}}, cur_off};
   assign conflict = (cur_off == C_PORT) &&
                     (((addr_q & C_MASK0) == C_VAL0) || ((addr_q & C_MASK1) == '0));

   assign in_x      = (state_q == ST_XFER);
   assign rd_ph     = in_x && (unit_q == U_RD);
   assign wr_ph     = in_x && (unit_q == U_BYTE_END);
   assign byte_end  = wr_ph;
   assign last_byte = (rem_q == REM_ONE);

   assign rd_o    = rd_ph && !conflict;
   assign wr_o    = wr_ph && !(conflict && !dir_q);
   assign addr_o  = (rd_ph ^ dir_q) ? addr_q : b_addr;
   assign wdata_o = conflict ? 8'h00 : dbuf_q;

   assign load_o = (state_q == ST_IDLE) && start_i;
   assign clr_o  = byte_end && last_byte;
   assign sel_o  = ch_q;
   assign busy_o = (state_q == ST_RUNOH) || (state_q == ST_SETUP) || in_x;
   assign lock_o = (state_q == ST_LOCK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         unit_q     <= '0;
         ch_q       <= '0;
         dir_q      <= 1'b0;
         addr_q     <= '0;
         off_base_q <= '0;
         pat_q      <= '0;
         pidx_q     <= '0;
         rem_q      <= '0;
         dbuf_q     <= '0;
      end else begin
         if (rd_o) dbuf_q <= rdata_i;
         case (state_q)
            ST_IDLE: begin
               unit_q <= '0;
               if (start_i) state_q <= ST_RUNOH;
            end
            ST_RUNOH: begin
               if (unit_q == U_RUN_END) begin
                  unit_q <= '0;
                  if (nxt_valid) begin
                     state_q <= ST_SETUP;
                     ch_q    <= nxt_idx;
                  end else begin
                     state_q <= ST_LOCK;
                  end
               end else begin
                  unit_q <= unit_q + UW'(1);
               end
            end
            ST_SETUP: begin
               if (unit_q == '0) begin
                  dir_q      <= sel_dir_i;
                  addr_q     <= sel_addr_i;
                  off_base_q <= sel_off_i;
                  pat_q      <= sel_pat_i;
                  pidx_q     <= '0;
                  rem_q      <= (sel_cnt_i == '0) ? REM_FULL : {1'b0, sel_cnt_i};
               end
               if (unit_q == U_SET_END) begin
                  unit_q  <= '0;
                  state_q <= ST_XFER;
               end else begin
                  unit_q <= unit_q + UW'(1);
               end
            end
            ST_XFER: begin
               if (byte_end) begin
                  unit_q <= '0;
                  rem_q  <= rem_q - REM_ONE;
                  addr_q <= addr_q + AW'(1);
                  pidx_q <= pidx_q + 2'd1;
                  if (last_byte) begin
                     if (nxt_valid) begin
                        state_q <= ST_SETUP;
                        ch_q    <= nxt_idx;
                     end else begin
                        state_q <= ST_LOCK;
                     end
                  end
               end else begin
                  unit_q <= unit_q + UW'(1);
               end
            end
            ST_LOCK: begin
               if (unit_q == U_LOCK_END) begin
                  unit_q  <= '0;
                  state_q <= ST_IDLE;
               end else begin
                  unit_q <= unit_q + UW'(1);
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_o && wr_o)); // R3

   AST_BUSY_LOCK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_o && lock_o)); // R12

   AST_LOCK_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_o) |-> $past(busy_o)); // R12

   AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SETUP && unit_q == '0 && $past(state_q) == ST_XFER)
      |-> (ch_q > $past(ch_q))); // R1

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_end && !last_byte) |=> (addr_q == $past(addr_q) + AW'(1))); // R9

   AST_DIR0_CONFLICT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_x && conflict && !dir_q) |-> !(rd_o || wr_o)); // R6

   AST_REM_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      in_x |-> (rem_q != '0)); // R8

   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && (busy_o || lock_o)) |-> !load_o); // R13

endmodule

// File: rtl/dma_seq.sv
module dma_seq #(
   parameter int NCH      = 8,
   parameter int AW       = 24,
   parameter int CNT_W    = 16,
   parameter int RUN_OH   = 8,
   parameter int SETUP_OH = 8,
   parameter int HALF     = 4,
   parameter int LOCK_LEN = 2,
   localparam int IDX_W   = $clog2(NCH)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [NCH-1:0]       cfg_en_i,
   input  logic [NCH-1:0]       cfg_dir_i,
   input  logic [NCH*AW-1:0]    cfg_addr_i,
   input  logic [NCH*8-1:0]     cfg_off_i,
   input  logic [NCH*2-1:0]     cfg_pat_i,
   input  logic [NCH*CNT_W-1:0] cfg_cnt_i,
   input  logic [7:0]           rdata_i,
   output logic                 rd_o,
   output logic                 wr_o,
   output logic [AW-1:0]        addr_o,
   output logic [7:0]           wdata_o,
   output logic                 busy_o,
   output logic                 lock_o,
   output logic [NCH-1:0]       en_o
);

   initial begin : elab_checks
      assert (NCH >= 2 && NCH <= 32 && (1 << IDX_W) == NCH)
         else $error("NCH must be a power of two in 2..32");
      assert (AW == 24) else $error("AW must be 24 for the conflict decode");
      assert (CNT_W >= 2 && CNT_W <= 24) else $error("CNT_W out of range");
      assert (RUN_OH >= 1 && SETUP_OH >= 1 && HALF >= 1 && LOCK_LEN >= 1)
         else $error("timing parameters must be at least 1");
   end

   logic             load, clr, sel_dir;
   logic [IDX_W-1:0] sel;
   logic [AW-1:0]    sel_addr;
   logic [7:0]       sel_off;
   logic [1:0]       sel_pat;
   logic [CNT_W-1:0] sel_cnt;

   dma_seq_chan_bank #(.NCH(NCH), .AW(AW), .CNT_W(CNT_W)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load),
      .cfg_en_i   (cfg_en_i),
      .cfg_dir_i  (cfg_dir_i),
      .cfg_addr_i (cfg_addr_i),
      .cfg_off_i  (cfg_off_i),
      .cfg_pat_i  (cfg_pat_i),
      .cfg_cnt_i  (cfg_cnt_i),
      .clr_i      (clr),
      .sel_i      (sel),
      .en_o       (en_o),
      .sel_dir_o  (sel_dir),
      .sel_addr_o (sel_addr),
      .sel_off_o  (sel_off),
      .sel_pat_o  (sel_pat),
      .sel_cnt_o  (sel_cnt)
   );

   dma_seq_engine #(
      .NCH(NCH), .AW(AW), .CNT_W(CNT_W), .RUN_OH(RUN_OH),
      .SETUP_OH(SETUP_OH), .HALF(HALF), .LOCK_LEN(LOCK_LEN)
   ) u_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .en_i       (en_o),
      .sel_dir_i  (sel_dir),
      .sel_addr_i (sel_addr),
      .sel_off_i  (sel_off),
      .sel_pat_i  (sel_pat),
      .sel_cnt_i  (sel_cnt),
      .rdata_i    (rdata_i),
      .load_o     (load),
      .clr_o      (clr),
      .sel_o      (sel),
      .rd_o       (rd_o),
      .wr_o       (wr_o),
      .addr_o     (addr_o),
      .wdata_o    (wdata_o),
      .busy_o     (busy_o),
      .lock_o     (lock_o)
   );

endmodule

// File: tb/dma_seq_bench.sv
`timescale 1ns/1ps
module dma_seq_bench;

   localparam int NCH  = 8;
   localparam int AW   = 24;
   localparam int CW   = 10;
   localparam int MAXE = 160;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic [NCH-1:0]    cfg_en_i = '0, cfg_dir_i = '0;
   logic [NCH*AW-1:0] cfg_addr_i = '0;
   logic [NCH*8-1:0]  cfg_off_i = '0;
   logic [NCH*2-1:0]  cfg_pat_i = '0;
   logic [NCH*CW-1:0] cfg_cnt_i = '0;
   logic [7:0]  rdata_i;
   logic        rd_o, wr_o, busy_o, lock_o;
   logic [AW-1:0] addr_o;
   logic [7:0]  wdata_o;
   logic [NCH-1:0] en_o;

   always #4 clk = ~clk;

   function automatic logic [7:0] mem_f(input logic [23:0] a);
      return a[7:0] ^ a[15:8] ^ {a[22:16], a[23]} ^ 8'h3C;
   endfunction

   assign rdata_i = mem_f(addr_o);

   dma_seq #(.CNT_W(CW)) u_dma_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .cfg_en_i(cfg_en_i), .cfg_dir_i(cfg_dir_i), .cfg_addr_i(cfg_addr_i),
      .cfg_off_i(cfg_off_i), .cfg_pat_i(cfg_pat_i), .cfg_cnt_i(cfg_cnt_i),
      .rdata_i(rdata_i), .rd_o(rd_o), .wr_o(wr_o), .addr_o(addr_o),
      .wdata_o(wdata_o), .busy_o(busy_o), .lock_o(lock_o), .en_o(en_o)
   );

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // Monitor: event = {cycle[19:0], kind[1:0], addr[23:0], data[7:0]}
   logic [63:0] ev [MAXE];
   int ev_n, tick, t0, lock_t, lock_len;
   bit busy_prev, lock_prev, lock_busy;

   always @(negedge clk) begin
      if (busy_o && !busy_prev) t0 = tick;
      if (rd_o || wr_o) begin
         if (ev_n < MAXE)
            ev[ev_n] = {12'd0, 20'(tick - t0), rd_o ? 2'd1 : 2'd2, addr_o, rd_o ? rdata_i : wdata_o};
         ev_n++;
      end
      if (lock_o && !lock_prev) begin
         lock_t = tick - t0;
         lock_busy = busy_o;
      end
      if (lock_o) lock_len++;
      busy_prev = busy_o;
      lock_prev = lock_o;
      tick++;
   end

   // Reference model
   logic [63:0] xev [MAXE];
   int xn, xlock;

   function automatic logic [7:0] delta_f(input logic [1:0] p, input logic [1:0] k);
      case (p)
         2'd0: return 8'd0;
         2'd1: return {7'd0, k[0]};
         2'd2: return {7'd0, k[1]};
         default: return {6'd0, k};
      endcase
   endfunction

   task automatic add_ev(input int cyc, input logic [1:0] kind, input logic [23:0] a, input logic [7:0] d);
      if (xn < MAXE) xev[xn] = {12'd0, 20'(cyc), kind, a, d};
      xn++;
   endtask

   // Vector: en[65:58] dir[57:50] abase[49:26] off[25:18] pat[17:16] cnt[15:0]
   localparam logic [65:0] VEC [9] = '{
      {8'h05, 8'h00, 24'h018000, 8'h18, 2'd0, 16'd3},   // R1 skip, R4 dir0
      {8'hA0, 8'hFF, 24'h029000, 8'h04, 2'd3, 16'd5},   // R4 dir1, R10 pat3
      {8'hFF, 8'h55, 24'h03A000, 8'h40, 2'd1, 16'd2},   // R1 all channels
      {8'h01, 8'h00, 24'h7E0010, 8'h80, 2'd0, 16'd3},   // R5 R6 bank 7E
      {8'h01, 8'hFF, 24'h001FFE, 8'h80, 2'd0, 16'd4},   // R5 R7 low window edge
      {8'h01, 8'h00, 24'h7EFFFE, 8'h7F, 2'd3, 16'd4},   // R5 R10 offset reaches 0x80
      {8'h00, 8'h00, 24'h000000, 8'h00, 2'd0, 16'd1},   // R12 nothing armed
      {8'h01, 8'hFF, 24'hFFFFFE, 8'h10, 2'd2, 16'd3},   // R9 wrap, R10 pat2
      {8'h01, 8'h00, 24'h100000, 8'h20, 2'd3, 16'd0}    // R8 zero count
   };

   task automatic build_model(input logic [65:0] v);
      int cyc;
      xn = 0;
      cyc = 8;
      for (int c = 0; c < NCH; c++) begin
         if (v[58 + c]) begin
            logic [23:0] a;
            logic [CW-1:0] cnt;
            int n;
            cyc += 8;
            a = v[49:26] + (24'(c) << 16);
            cnt = CW'(v[15:0] + 16'(c));
            n = (cnt == 0) ? (1 << CW) : int'(cnt);
            for (int j = 0; j < n; j++) begin
               logic [7:0] off;
               logic [23:0] ba;
               bit ill;
               off = v[25:18] + delta_f(v[17:16], 2'(j));
               ba = {16'h0021, off};
               ill = (off == 8'h80) && (((a & 24'hFE0000) == 24'h7E0000) || ((a & 24'h40E000) == 0));
               if (!v[50 + c]) begin
                  if (!ill) begin
                     add_ev(cyc + 3, 2'd1, a, mem_f(a));
                     add_ev(cyc + 7, 2'd2, ba, mem_f(a));
                  end
               end else begin
                  if (!ill) begin
                     add_ev(cyc + 3, 2'd1, ba, mem_f(ba));
                     add_ev(cyc + 7, 2'd2, a, mem_f(ba));
                  end else begin
                     add_ev(cyc + 7, 2'd2, a, 8'h00);
                  end
               end
               a = a + 24'd1;
               cyc += 8;
            end
         end
      end
      xlock = cyc;
   endtask

   task automatic apply_cfg(input logic [65:0] v);
      cfg_en_i  = v[65:58];
      cfg_dir_i = v[57:50];
      for (int c = 0; c < NCH; c++) begin
         cfg_addr_i[c*AW +: AW] = v[49:26] + (24'(c) << 16);
         cfg_off_i[c*8 +: 8]    = v[25:18];
         cfg_pat_i[c*2 +: 2]    = v[17:16];
         cfg_cnt_i[c*CW +: CW]  = CW'(v[15:0] + 16'(c));
      end
   endtask

   // mode 0 plain, 1 restart attempt mid-run, 2 enable probe
   task automatic run_case(input int id, input logic [65:0] v, input int mode);
      int rel, guard;
      bit seen;
      build_model(v);
      apply_cfg(v);
      ev_n = 0; lock_len = 0; lock_t = -1; lock_busy = 0;
      start_i = 1'b1;
      @(negedge clk); #1;
      start_i = 1'b0;
      chk(busy_o == 1'b1, $sformatf("R2 busy after start case %0d", id), 64'(busy_o), 64'd1);
      rel = 0; guard = 0; seen = 0;
      while (!(seen && !lock_o) && guard < 20000) begin
         if (mode == 1 && rel == 20) begin start_i = 1'b1; cfg_en_i = '1; end
         if (mode == 1 && rel == 21) start_i = 1'b0;
         if (mode == 1 && rel == 24) chk(en_o == v[65:58], "R13 enables untouched by restart", 64'(en_o), 64'(v[65:58]));
         if (mode == 2 && rel == 30) chk(en_o == 8'h05, "R11 enables before first channel ends", 64'(en_o), 64'h05);
         if (mode == 2 && rel == 40) chk(en_o == 8'h04, "R11 enable cleared after last byte", 64'(en_o), 64'h04);
         if (lock_o) seen = 1;
         @(negedge clk); #1;
         rel++; guard++;
      end
      chk(ev_n == xn, $sformatf("R1/R8 strobe count case %0d", id), 64'(ev_n), 64'(xn));
      for (int i = 0; i < xn && i < MAXE && i < ev_n; i++)
         chk(ev[i] == xev[i], $sformatf("R3/R4/R5/R6/R7/R9/R10 event %0d case %0d", i, id), ev[i], xev[i]);
      chk(lock_t == xlock, $sformatf("R2/R12 lock cycle case %0d", id), 64'(lock_t), 64'(xlock));
      chk(lock_len == 2 && !lock_busy, $sformatf("R12 lock width case %0d", id), 64'(lock_len), 64'd2);
      chk(en_o == '0, $sformatf("R11 enables clear at end case %0d", id), 64'(en_o), 64'd0);
      @(negedge clk); #1;
   endtask

   initial begin
      ev_n = 0; tick = 0; t0 = 0; lock_len = 0; lock_t = -1;
      repeat (3) @(negedge clk);
      #1;
      chk(!busy_o && !lock_o && !rd_o && !wr_o && en_o == '0, "reset state R11/R12",
          {busy_o, lock_o, rd_o, wr_o, en_o}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk(!busy_o && !lock_o, "R2 idle without start", {busy_o, lock_o}, 64'd0);
      for (int k = 0; k < 9; k++) run_case(k, VEC[k], 0);
      run_case(20, VEC[0], 2);
      run_case(21, VEC[1], 1);
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not complete");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule